// File: doc/BRIEF.md
# Sub-clock 16-bit interval timer

This block is a free-running 16-bit binary down counter that advances on count pulses derived from a slow sub-clock. The sub-clock arrives already synchronized, as a single-cycle enable pulse in the system clock domain, so the whole block runs on one clock. A small control word sets the run state and picks one of four power-of-two underflow intervals. Each time the selected interval expires, the block emits a one-cycle flag-set pulse that an interrupt controller turns into a request flag. The counter then keeps going without reloading.

Stopping the timer presets the counter to all ones. Starting it again therefore always begins a full interval from a known point. Counter bit 4 is driven out as a slow square-wave count source for a downstream display divider. The timer also keeps counting while the chip sits in its low-power clock mode. In that mode, an interval expiry additionally raises a wake-up pulse for the power controller.

Top module: `subclk_interval_timer`

## Requirements
- R1: After reset the counter reads 16'hFFFF, the timer is stopped, and `irq_set` and `wake` are low.
- R2: While the run bit (`ctrl_wdata[2]` as last written) is 0, `sub_tick` pulses are ignored and the counter stays at 16'hFFFF.
- R3: While running, each cycle with `sub_tick` high lowers the counter by one at that clock edge. A cycle without `sub_tick` leaves the counter unchanged. The count wraps from 16'h0000 to 16'hFFFF.
- R4: The interval code `ctrl_wdata[1:0]` selects the flag period in `sub_tick` pulses: 0 gives 65536, 1 gives 32768, 2 gives 16384 and 3 gives 8192. Starting from 16'hFFFF, the first flag comes on the pulse whose ordinal equals the period.
- R5: `irq_set` is high for exactly one cycle per expiry. It is visible in the cycle right after the edge that performed the expiring count step.
- R6: A control write with bit 2 clear loads 16'hFFFF into the counter at that write's clock edge and produces no flag.
- R7: `lcd_src` always equals counter bit 4.
- R8: `wake` pulses together with `irq_set` only when `pdown` was high in the cycle of the expiring step. Otherwise it stays low.
- R9: A control write that keeps bit 2 set, whether or not it changes the interval code, leaves the running count undisturbed.
- R10: When a write clearing bit 2 coincides with a `sub_tick` pulse, the preset wins: the counter reads 16'hFFFF and no flag is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 3 | Control word: [1:0] interval code, [2] run |
| sub_tick | input | 1 | Synchronized one-cycle sub-clock count pulse |
| pdown | input | 1 | High while the chip is in low-power clock mode |
| cnt_o | output | 16 | Current counter value |
| lcd_src | output | 1 | Counter bit 4, count source for the display divider |
| irq_set | output | 1 | One-cycle interrupt flag-set pulse |
| wake | output | 1 | One-cycle wake-up pulse issued in low-power mode |

## Verification
Control writes and count steps take effect at the edge where they are presented, so `cnt_o` and `lcd_src` show the new value one edge later. `irq_set` and `wake` come from a single register stage and appear in that same post-edge cycle. The bench drives every input on the falling edge and samples on the next falling edge. Each result is therefore compared exactly one edge after its stimulus, and flag pulses are matched to the ordinal of the tick that caused them. Idle cycles interleaved between ticks check that nothing moves without a pulse.

// File: rtl/sit_pkg.sv
package sit_pkg;

   // Counter bit whose 0->1 transition marks expiry for a given interval code.
   function automatic int sit_tap_pos(input int width, input int code);
      return width - 1 - code;
   endfunction

endpackage

// File: rtl/sit_ctrl.sv
module sit_ctrl #(
   parameter int SEL_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [SEL_W:0]   wdata,
   output logic             run_q,
   output logic [SEL_W-1:0] code_q,
   output logic             stop_now
);

   assign stop_now = we & ~wdata[SEL_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         code_q <= '0;
      end else if (we) begin
         run_q  <= wdata[SEL_W];
         code_q <= wdata[SEL_W-1:0];
      end
   end

endmodule

// File: rtl/sit_count.sv
module sit_count #(
   parameter int WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             preset,
   input  logic             step,
   output logic [WIDTH-1:0] cnt_q,
   output logic [WIDTH-1:0] cnt_d
);

   always_comb begin
      if (preset)
         cnt_d = '1;
      else if (step)
         cnt_d = cnt_q - 1'b1;
      else
         cnt_d = cnt_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '1;
      else        cnt_q <= cnt_d;
   end

endmodule

// File: rtl/sit_event.sv
module sit_event
   import sit_pkg::*;
#(
   parameter int WIDTH = 16,
   parameter int SEL_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic [WIDTH-1:0] cnt_q,
   input  logic [WIDTH-1:0] cnt_d,
   input  logic [SEL_W-1:0] code_q,
   input  logic             pdown,
   output logic             irq_q,
   output logic             wake_q
);

   localparam int N_CODE = 2 ** SEL_W;

   logic [N_CODE-1:0] rise;

   for (genvar c = 0; c < N_CODE; c++) begin : g_tap
      localparam int TAP = sit_tap_pos(WIDTH, c);
      assign rise[c] = step & ~cnt_q[TAP] & cnt_d[TAP];
   end

   logic hit;
   assign hit = rise[code_q];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_q  <= 1'b0;
         wake_q <= 1'b0;
      end else begin
         irq_q  <= hit;
         wake_q <= hit & pdown;
      end
   end

endmodule

// File: rtl/subclk_interval_timer.sv
module subclk_interval_timer #(
   parameter int WIDTH   = 16,
   parameter int SEL_W   = 2,
   parameter int LCD_BIT = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctrl_we,
   input  logic [SEL_W:0]   ctrl_wdata,
   input  logic             sub_tick,
   input  logic             pdown,
   output logic [WIDTH-1:0] cnt_o,
   output logic             lcd_src,
   output logic             irq_set,
   output logic             wake
);

   localparam int N_CODE = 2 ** SEL_W;

   if (WIDTH < N_CODE + 1) begin : g_bad_width
      $error("WIDTH too small for the interval code range");
   end
   if (LCD_BIT >= WIDTH) begin : g_bad_lcd
      $error("LCD_BIT outside the counter");
   end

   logic             run_q;
   logic [SEL_W-1:0] code_q;
   logic             stop_now;
   logic             step;
   logic             preset;
   logic [WIDTH-1:0] cnt_q;
   logic [WIDTH-1:0] cnt_d;

   sit_ctrl #(.SEL_W(SEL_W)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (ctrl_we),
      .wdata    (ctrl_wdata),
      .run_q    (run_q),
      .code_q   (code_q),
      .stop_now (stop_now)
   );

   assign preset = stop_now | ~run_q;
   assign step   = run_q & sub_tick & ~stop_now;

   sit_count #(.WIDTH(WIDTH)) u_count (
      .clk    (clk),
      .rst_n  (rst_n),
      .preset (preset),
      .step   (step),
      .cnt_q  (cnt_q),
      .cnt_d  (cnt_d)
   );

   sit_event #(.WIDTH(WIDTH), .SEL_W(SEL_W)) u_event (
      .clk    (clk),
      .rst_n  (rst_n),
      .step   (step),
      .cnt_q  (cnt_q),
      .cnt_d  (cnt_d),
      .code_q (code_q),
      .pdown  (pdown),
      .irq_q  (irq_set),
      .wake_q (wake)
   );

   assign cnt_o   = cnt_q;
   assign lcd_src = cnt_q[LCD_BIT];

endmodule

// File: rtl/sit_checker.sv
module sit_checker #(
   parameter int WIDTH = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ctrl_we,
   input logic             stop_wr,
   input logic             sub_tick,
   input logic             pdown,
   input logic             run_q,
   input logic [WIDTH-1:0] cnt_o,
   input logic             irq_set,
   input logic             wake
);

   a_r6_stop_presets: assert property (@(posedge clk) disable iff (!rst_n)
      stop_wr |=> cnt_o == {WIDTH{1'b1}});

   a_r2_idle_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q && !ctrl_we) |=> cnt_o == {WIDTH{1'b1}});

   a_r3_step_down: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && sub_tick && !ctrl_we) |=> cnt_o == $past(cnt_o) - 1'b1);

   a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!sub_tick && !ctrl_we) |=> $stable(cnt_o));

   a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      irq_set |=> !irq_set);

   a_r5_from_step: assert property (@(posedge clk) disable iff (!rst_n)
      irq_set |-> $past(sub_tick && run_q));

   a_r8_wake_gated: assert property (@(posedge clk) disable iff (!rst_n)
      wake |-> (irq_set && $past(pdown)));

   a_r10_no_flag_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
      stop_wr |=> !irq_set);

endmodule

bind subclk_interval_timer sit_checker #(.WIDTH(WIDTH)) u_sit_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .ctrl_we  (ctrl_we),
   .stop_wr  (ctrl_we & ~ctrl_wdata[SEL_W]),
   .sub_tick (sub_tick),
   .pdown    (pdown),
   .run_q    (run_q),
   .cnt_o    (cnt_o),
   .irq_set  (irq_set),
   .wake     (wake)
);

// File: tb/subclk_interval_timer_bench.sv
module subclk_interval_timer_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ctrl_we = 1'b0;
   logic [2:0]  ctrl_wdata = 3'b000;
   logic        sub_tick = 1'b0;
   logic        pdown = 1'b0;
   logic [15:0] cnt_o;
   logic        lcd_src;
   logic        irq_set;
   logic        wake;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   bit done   = 1'b0;
   logic [15:0] exp_cnt;

   always #4 clk = ~clk;

   subclk_interval_timer u_subclk_interval_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .ctrl_we    (ctrl_we),
      .ctrl_wdata (ctrl_wdata),
      .sub_tick   (sub_tick),
      .pdown      (pdown),
      .cnt_o      (cnt_o),
      .lcd_src    (lcd_src),
      .irq_set    (irq_set),
      .wake       (wake)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic write_ctrl(input bit run, input logic [1:0] code);
      ctrl_we = 1'b1;
      ctrl_wdata = {run, code};
      @(negedge clk);
      ctrl_we = 1'b0;
   endtask

   // Apply n back-to-back ticks; collect flag statistics.
   task automatic run_ticks(input int n, input int period, input bit want_wake,
                            output int nirq, output int nbad);
      nirq = 0;
      nbad = 0;
      for (int i = 1; i <= n; i++) begin
         sub_tick = 1'b1;
         @(negedge clk);
         exp_cnt = exp_cnt - 16'd1;
         if (irq_set) nirq++;
         if (irq_set !== ((i % period) == 0)) nbad++;
         if (wake !== (want_wake && ((i % period) == 0))) nbad++;
         if (lcd_src !== exp_cnt[4]) nbad++;
      end
      sub_tick = 1'b0;
   endtask

   task automatic t_reset();
      chk(cnt_o == 16'hFFFF, "R1 reset count", cnt_o, 16'hFFFF);
      chk(!irq_set && !wake, "R1 reset flags", {irq_set, wake}, 0);
      chk(lcd_src == 1'b1, "R7 lcd at reset", lcd_src, 1);
   endtask

   task automatic t_stopped();
      write_ctrl(1'b0, 2'd3);
      for (int i = 0; i < 20; i++) begin
         sub_tick = 1'b1;
         @(negedge clk);
         chk(cnt_o == 16'hFFFF && !irq_set, "R2 ticks ignored when stopped", cnt_o, 16'hFFFF);
      end
      sub_tick = 1'b0;
   endtask

   task automatic t_interval(input logic [1:0] code, input int n, input int exp_irqs);
      int nirq, nbad, period;
      period = 1 << (16 - code);
      write_ctrl(1'b1, code);
      exp_cnt = 16'hFFFF;
      run_ticks(n, period, 1'b0, nirq, nbad);
      chk(nirq == exp_irqs, "R4 flag count for interval", nirq, exp_irqs);
      chk(nbad == 0, "R5/R7/R8 per-tick flag, wake and lcd", nbad, 0);
      chk(cnt_o == exp_cnt, "R3 count after ticks", cnt_o, exp_cnt);
      @(negedge clk);
      chk(!irq_set, "R5 flag drops after one cycle", irq_set, 0);
      write_ctrl(1'b0, code);
      chk(cnt_o == 16'hFFFF && !irq_set, "R6 stop presets count", cnt_o, 16'hFFFF);
   endtask

   task automatic t_gaps();
      write_ctrl(1'b1, 2'd3);
      exp_cnt = 16'hFFFF;
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         chk(cnt_o == exp_cnt, "R3 idle cycle holds count", cnt_o, exp_cnt);
         sub_tick = 1'b1;
         @(negedge clk);
         sub_tick = 1'b0;
         exp_cnt = exp_cnt - 16'd1;
         chk(cnt_o == exp_cnt, "R3 tick lowers count", cnt_o, exp_cnt);
      end
   endtask

   task automatic t_rewrite();
      int nirq, nbad;
      run_ticks(90, 8192, 1'b0, nirq, nbad);
      write_ctrl(1'b1, 2'd0);
      chk(cnt_o == exp_cnt, "R9 rewrite keeps count", cnt_o, exp_cnt);
      sub_tick = 1'b1;
      @(negedge clk);
      sub_tick = 1'b0;
      exp_cnt = exp_cnt - 16'd1;
      chk(cnt_o == exp_cnt, "R9 counting continues", cnt_o, exp_cnt);
   endtask

   task automatic t_stop_with_tick();
      ctrl_we = 1'b1;
      ctrl_wdata = 3'b011;
      sub_tick = 1'b1;
      @(negedge clk);
      ctrl_we = 1'b0;
      sub_tick = 1'b0;
      chk(cnt_o == 16'hFFFF, "R10 preset beats tick", cnt_o, 16'hFFFF);
      chk(!irq_set, "R10 no flag on stop", irq_set, 0);
   endtask

   task automatic t_wake();
      int nirq, nbad;
      pdown = 1'b1;
      write_ctrl(1'b1, 2'd3);
      exp_cnt = 16'hFFFF;
      run_ticks(8192, 8192, 1'b1, nirq, nbad);
      chk(nirq == 1, "R8 one expiry in power-down", nirq, 1);
      chk(nbad == 0, "R8 wake coincides with flag", nbad, 0);
      pdown = 1'b0;
      write_ctrl(1'b0, 2'd3);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_stopped();
      t_interval(2'd3, 16384, 2);
      t_interval(2'd2, 16384, 1);
      t_interval(2'd1, 32768, 1);
      t_interval(2'd0, 65536, 1);
      t_gaps();
      t_rewrite();
      t_stop_with_tick();
      t_wake();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 190000 && !done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog R1..all actual=%0d expected<190000", cyc);
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

endmodule